// File: doc/BRIEF.md
# ADC Result Window Monitor

This block watches the stream of 12-bit conversion results as they leave a converter's sampling engine. It raises a sticky alarm when a result lands outside a programmable window set by a low bound and a high bound. Each result arrives with a valid strobe, its channel number and a bit that tells whether it belongs to the regular group or the injected group. The window check runs on the raw result, before any alignment or offset step downstream.

Monitoring is switched on separately for each group. A filter chooses between two modes: checking every result of an enabled group, or checking only one chosen channel. The same chosen channel applies to both groups. The alarm stays set until a clear pulse arrives. An interrupt output passes the alarm through a separate enable.

Top module: `adc_window_watch`

## Requirements
- R1: After reset, `wdFlag` and `wdIrq` are both 0.
- R2: A checked result strictly greater than `thrHigh` sets `wdFlag` at the next rising clock edge.
- R3: A checked result strictly less than `thrLow` sets `wdFlag` at the next rising clock edge.
- R4: A checked result that satisfies `thrLow <= result <= thrHigh` does not set `wdFlag`. A result equal to either bound counts as inside the window.
- R5: A result with `resInjected`=0 is regular and is checked only when `regEn`=1. A result with `resInjected`=1 is injected and is checked only when `injEn`=1. With both enables at 0, `wdFlag` never sets.
- R6: With `singleChan`=1, only results whose `resChan` equals `selChan` are checked. This single channel number applies to regular and injected results alike.
- R7: With `singleChan`=0, every result from an enabled group is checked, whatever its channel number.
- R8: Once set, `wdFlag` stays at 1 until `flagClear` is high at a rising edge, which clears it at that edge. If a violating result is checked at the same edge, the flag stays at 1.
- R9: `wdIrq` equals `wdFlag` AND `irqEn` at all times.
- R10: When `resValid` is 0, the other result inputs have no effect on `wdFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Result strobe, one cycle per result |
| resData | input | 12 | Raw conversion result |
| resChan | input | 5 | Channel number of the result |
| resInjected | input | 1 | 1 = injected group, 0 = regular group |
| thrLow | input | 12 | Lower window bound |
| thrHigh | input | 12 | Upper window bound |
| regEn | input | 1 | Check regular results |
| injEn | input | 1 | Check injected results |
| singleChan | input | 1 | 1 = check only `selChan`, 0 = check all channels |
| selChan | input | 5 | Channel to check in single-channel mode |
| irqEn | input | 1 | Interrupt enable |
| flagClear | input | 1 | Clear pulse for the alarm |
| wdFlag | output | 1 | Sticky out-of-window alarm |
| wdIrq | output | 1 | Gated interrupt |

## Verification
The bench builds the block with its default 12-bit result width and 5-bit channel number. With these values it can drive the extreme codes 0 and 4095 and the top channel 31 directly. A hand-built list then covers the exact bounds, the two group enables in every combination, the channel filter on both groups, and the case where a clear and a violation arrive together. After that list, a long run of random results, channels and configuration changes is compared against a behavioural model every cycle, so the mode combinations also appear with interleaved clears.

// File: rtl/awd_pkg.sv
package awd_pkg;
  // Strobes handed from qualification control to the comparison datapath
  typedef struct packed {
    logic check;  // this cycle's result must be compared against the window
    logic clear;  // drop the sticky alarm
  } awd_strobe_t;
endpackage

// File: rtl/awd_ctrl.sv
module awd_ctrl
  import awd_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resValid,
  input  logic [CH_W-1:0] resChan,
  input  logic            resInjected,
  input  logic            regEn,
  input  logic            injEn,
  input  logic            singleChan,
  input  logic [CH_W-1:0] selChan,
  input  logic            flagClear,
  output awd_strobe_t     strb
);

  logic groupOn;
  logic chanOk;

  always_comb begin
    groupOn    = resInjected ? injEn : regEn;
    chanOk     = !singleChan || (resChan == selChan);
    strb.check = resValid && groupOn && chanOk;
    strb.clear = flagClear;
  end

  AST_IDLE_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !strb.check);  // R10
  AST_GROUPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!regEn && !injEn) |-> !strb.check);  // R5
  AST_CHAN_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (singleChan && resChan != selChan) |-> !strb.check);  // R6

endmodule

// File: rtl/awd_dp.sv
module awd_dp
  import awd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  awd_strobe_t       strb,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] thrLow,
  input  logic [DATA_W-1:0] thrHigh,
  output logic              flag
);

  logic aboveHigh;
  logic belowLow;
  logic violation;

  always_comb begin
    aboveHigh = resData > thrHigh;
    belowLow  = resData < thrLow;
    violation = strb.check && (aboveHigh || belowLow);
  end

  // A fresh violation outranks a clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (violation)  flag <= 1'b1;
    else if (strb.clear) flag <= 1'b0;
  end

  AST_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.check && resData > thrHigh) |=> flag);  // R2
  AST_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.check && resData < thrLow) |=> flag);  // R3
  AST_INSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && resData >= thrLow && resData <= thrHigh) |=> !flag);  // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !strb.clear) |=> flag);  // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clear && !strb.check) |=> !flag);  // R8

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic [CH_W-1:0]   resChan,
  input  logic              resInjected,
  input  logic [DATA_W-1:0] thrLow,
  input  logic [DATA_W-1:0] thrHigh,
  input  logic              regEn,
  input  logic              injEn,
  input  logic              singleChan,
  input  logic [CH_W-1:0]   selChan,
  input  logic              irqEn,
  input  logic              flagClear,
  output logic              wdFlag,
  output logic              wdIrq
);

  awd_strobe_t strb;

  awd_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .resValid   (resValid),
    .resChan    (resChan),
    .resInjected(resInjected),
    .regEn      (regEn),
    .injEn      (injEn),
    .singleChan (singleChan),
    .selChan    (selChan),
    .flagClear  (flagClear),
    .strb       (strb)
  );

  awd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .resData(resData),
    .thrLow (thrLow),
    .thrHigh(thrHigh),
    .flag   (wdFlag)
  );

  assign wdIrq = wdFlag & irqEn;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEn |-> !wdIrq);  // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEn && wdFlag) |-> wdIrq);  // R9

endmodule

// File: tb/adc_window_watch_test.sv
module adc_window_watch_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        resValid;
  logic [11:0] resData;
  logic [4:0]  resChan;
  logic        resInjected;
  logic [11:0] thrLow;
  logic [11:0] thrHigh;
  logic        regEn;
  logic        injEn;
  logic        singleChan;
  logic [4:0]  selChan;
  logic        irqEn;
  logic        flagClear;
  logic        wdFlag;
  logic        wdIrq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  expFlag;

  always #4 clk = ~clk;  // 125 MHz

  adc_window_watch uut (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resData(resData),
    .resChan(resChan), .resInjected(resInjected), .thrLow(thrLow),
    .thrHigh(thrHigh), .regEn(regEn), .injEn(injEn), .singleChan(singleChan),
    .selChan(selChan), .irqEn(irqEn), .flagClear(flagClear),
    .wdFlag(wdFlag), .wdIrq(wdIrq)
  );

  task automatic check(input string tag);
    checks++;
    if (wdFlag !== expFlag) begin
      fails++;
      $display("FAIL %s flag actual=%0b expected=%0b", tag, wdFlag, expFlag);
    end
    checks++;
    if (wdIrq !== (expFlag & irqEn)) begin
      fails++;
      $display("FAIL R9 (%s) irq actual=%0b expected=%0b", tag, wdIrq, expFlag & irqEn);
    end
  endtask

  // Drive one cycle at the falling edge, advance the model at the rising edge,
  // compare at the following falling edge.
  task automatic cyc(input bit v, input int d, input int ch, input bit inj,
                     input bit clr, input string tag);
    bit mon;
    resValid = v; resData = 12'(d); resChan = 5'(ch);
    resInjected = inj; flagClear = clr;
    @(posedge clk);
    mon = v && (inj ? injEn : regEn) && (!singleChan || ch == int'(selChan));
    if (mon && (d > int'(thrHigh) || d < int'(thrLow))) expFlag = 1;
    else if (clr) expFlag = 0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 0; resValid = 0; resData = 0; resChan = 0; resInjected = 0;
    thrLow = 12'd100; thrHigh = 12'd3000; regEn = 1; injEn = 0;
    singleChan = 0; selChan = 0; irqEn = 1; flagClear = 0; expFlag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1");

    cyc(1, 3000, 0, 0, 0, "R4");
    cyc(1, 100, 0, 0, 0, "R4");
    cyc(1, 3001, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, "R8");
    cyc(1, 500, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(1, 99, 3, 0, 0, "R3");
    cyc(1, 4000, 3, 0, 1, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(0, 4095, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    thrLow = 0; thrHigh = 4095;
    cyc(1, 0, 0, 0, 0, "R4");
    cyc(1, 4095, 0, 0, 0, "R4");
    thrLow = 100; thrHigh = 3000;

    regEn = 1; injEn = 0;
    cyc(1, 4095, 0, 1, 0, "R5");
    regEn = 0; injEn = 1;
    cyc(1, 4095, 0, 0, 0, "R5");
    cyc(1, 4095, 0, 1, 0, "R5");
    cyc(0, 0, 0, 0, 1, "R8");
    regEn = 0; injEn = 0;
    cyc(1, 4095, 0, 0, 0, "R5");
    cyc(1, 0, 0, 1, 0, "R5");

    regEn = 1; injEn = 1; singleChan = 1; selChan = 7;
    cyc(1, 4095, 6, 1, 0, "R6");
    cyc(1, 0, 8, 0, 0, "R6");
    cyc(1, 4095, 7, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(1, 0, 7, 1, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R8");
    singleChan = 0;
    cyc(1, 4095, 31, 1, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(1, 3500, 31, 0, 0, "R7");
    irqEn = 0;
    cyc(0, 0, 0, 0, 0, "R9");
    irqEn = 1;
    cyc(0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, "R8");

    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        thrLow = 12'($urandom_range(0, 1500));
        thrHigh = 12'($urandom_range(1500, 4095));
        regEn = 1'($urandom); injEn = 1'($urandom);
        singleChan = 1'($urandom); selChan = 5'($urandom_range(0, 3));
      end
      irqEn = 1'($urandom);
      cyc(1'($urandom_range(0, 3) != 0), $urandom_range(0, 4095),
          $urandom_range(0, 3), 1'($urandom),
          $urandom_range(0, 9) == 0, "R7 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule